// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an 8-bit up-counter clocked from the system clock through a selectable divider. On every new count value it compares the count against a programmable compare byte. When they meet, it raises a one-clock event flag and can act on a single output line: toggle it, force it low or force it high. It can also optionally restart the count from zero. Software reaches the control byte, the compare byte and the live count over a small register port with a write strobe, a 2-bit address, write data and combinational read data.

A match is registered one clock late. The flag, the output action and the restart all take effect on the clock edge after the cycle that shows the matching count. At divide-by-1 the count reads C, 0, 1. At larger divisions, C stays visible for only one clock, and 0 fills the rest of that divider period before the normal increment to 1. The output line reaches the pin only when an external direction bit allows it and the compare action is not disconnected. The pulse-width bit is stored and read back but drives nothing.

Register map: address 0 is the control byte. Address 1 is the compare byte. Address 2 is the count, which is read-only and ignores writes. Address 3 reads zero.

Top module: `tmr_cmp_top`

## Requirements
- R1: After reset the control byte, compare byte and count read 0x00, and cmp_out and match_pulse are 0.
- R2: Control bit 7 always reads 0. Bits 6:0 read back as written: bit 6 pulse-width enable, bits 5:4 compare action, bit 3 restart-on-match, bits 2:0 clock select. The compare byte reads back as written.
- R3: Clock select 000 freezes the count and produces no match pulse.
- R4: Clock select 001 adds one to the count every clock. Without restart-on-match the count wraps from 255 to 0.
- R5: Clock select codes 010, 011, 100, 101, 110 and 111 advance the count once every 8, 32, 64, 128, 256 and 1024 clocks. The divider starts from zero when counting is enabled.
- R6: With restart-on-match and divide-by-1 and compare value C, the count reads C-1, C, 0, 1 on consecutive clocks.
- R7: With restart-on-match and divide-by-8, C is visible for one clock. 0 follows for the remaining 7 clocks of that period, and then 1.
- R8: match_pulse is high for exactly one clock, in the clock after the count first shows the compare value. Without restart the count keeps its normal sequence.
- R9: On a match the output register toggles for action 01, goes to 0 for action 10 and goes to 1 for action 11. Action 00 leaves it unchanged. cmp_out shows the output register.
- R10: cmp_oe is 1 exactly when dir_bit is 1 and the compare action is not 00.
- R11: A write to the compare byte applies to the count values that follow the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| dir_bit | input | 1 | External direction control for the output pin |
| cmp_out | output | 1 | Compare output register |
| cmp_oe | output | 1 | Output enable for the compare pin |
| match_pulse | output | 1 | One-clock compare event flag |

## Verification
The hardest case to reach is the divided clock combined with restart-on-match. The divider phase is not visible at the ports, so the stimulus enables counting from a stopped divider, where the phase is known to be zero. It then counts clocks from the enabling write and samples the count on the exact clock that C appears, the one after, the last clock of the zero-filled period, and the clock where 1 arrives. The same known phase is used to show that the flag fires once while C lingers for eight clocks without restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_CNT_W  = 8;
  localparam int TMR_PRE_W  = 10;
  localparam int TMR_ADDR_W = 2;

  localparam logic [TMR_ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [TMR_ADDR_W-1:0] A_CMP  = 2'd1;
  localparam logic [TMR_ADDR_W-1:0] A_CNT  = 2'd2;

  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TGL = 2'b01,
    ACT_LOW = 2'b10,
    ACT_HIGH = 2'b11
  } act_e;

  typedef struct packed {
    logic       pwm_en;
    act_e       act;
    logic       restart;
    logic [2:0] clk_sel;
  } ctrl_t;

  // Number of low divider bits that must be all ones for a tick.
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd2: div_shift = 3;
      3'd3: div_shift = 5;
      3'd4: div_shift = 6;
      3'd5: div_shift = 7;
      3'd6: div_shift = 8;
      3'd7: div_shift = 10;
      default: div_shift = 0;
    endcase
  endfunction

  function automatic logic [TMR_PRE_W-1:0] div_mask(input logic [2:0] sel);
    logic [TMR_PRE_W:0] one_hot;
    one_hot  = (TMR_PRE_W+1)'(1) << div_shift(sel);
    div_mask = TMR_PRE_W'(one_hot - 1'b1);
  endfunction

  function automatic logic next_line(input act_e act, input logic cur);
    case (act)
      ACT_TGL:  next_line = ~cur;
      ACT_LOW:  next_line = 1'b0;
      ACT_HIGH: next_line = 1'b1;
      default:  next_line = cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = TMR_CNT_W,
  parameter int ADDR_W = TMR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [7:0]        rdata_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == A_CMP)  cmp_q  <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = 8'({1'b0, ctrl_q});
      A_CMP:   rdata_o = 8'(cmp_q);
      A_CNT:   rdata_o = 8'(count_i);
      default: rdata_o = 8'h00;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;

  p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_CTRL) |=> (ctrl_q == $past(wdata_i[CTRL_W-1:0])));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_W = TMR_PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  output logic       en_o,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask_w;

  assign en_o   = (sel_i != 3'd0);
  assign mask_w = div_mask(sel_i);
  assign tick_o = en_o && ((pre_q & mask_w) == mask_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!en_o)  pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R5: a divided tick is never followed at once by another with the same select
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && mask_w != '0) |=> (!tick_o || sel_i != $past(sel_i)));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  logic [CNT_W-1:0] count_q;
  logic             fresh_q;   // count holds a value loaded on the last edge
  logic             clear_w;

  assign match_o = en_i && fresh_q && (count_q == cmp_i);
  assign clear_w = restart_i && match_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= tick_i || clear_w;
      if (clear_w)     count_q <= '0;
      else if (tick_i) count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (count_q == $past(count_q)));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && match_o) |=> (count_q == '0));
  p_free_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && tick_i) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  act_e act_i,
  input  logic dir_i,
  output logic line_o,
  output logic oe_o,
  output logic pulse_o
);
  logic line_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= match_i;
      if (match_i) line_q <= next_line(act_i, line_q);
    end
  end

  assign line_o  = line_q;
  assign pulse_o = pulse_q;
  assign oe_o    = dir_i && (act_i != ACT_OFF);

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && act_i == ACT_TGL) |=> (line_q != $past(line_q)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !match_i |=> $stable(line_q));
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
  import tmr_pkg::*;
#(
  parameter int CNT_W  = TMR_CNT_W,
  parameter int PRE_W  = TMR_PRE_W,
  parameter int ADDR_W = TMR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dir_bit,
  output logic              cmp_out,
  output logic              cmp_oe,
  output logic              match_pulse
);
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] count_w;
  logic             en_w;
  logic             tick_w;
  logic             match_w;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .count_i(count_w), .ctrl_o(ctrl_w),
    .cmp_o(cmp_w), .rdata_o(bus_rdata)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel_i(ctrl_w.clk_sel),
    .en_o(en_w), .tick_o(tick_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .tick_i(tick_w),
    .restart_i(ctrl_w.restart), .cmp_i(cmp_w),
    .count_o(count_w), .match_o(match_w)
  );

  tmr_cmp_out u_out (
    .clk(clk), .rst_n(rst_n), .match_i(match_w), .act_i(ctrl_w.act),
    .dir_i(dir_bit), .line_o(cmp_out), .oe_o(cmp_oe), .pulse_o(match_pulse)
  );

  // R7: the flag lands together with the restart to zero
  p_flag_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && $past(ctrl_w.restart) && $past(en_w)) |-> (count_w == '0));
  p_oe_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_oe |-> (dir_bit && ctrl_w.act != ACT_OFF));
endmodule

// File: tb/tmr_cmp_top_tb_top.sv
`timescale 1ns/1ps
module tmr_cmp_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       dir_bit = 1'b0;
  logic       cmp_out, cmp_oe, match_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_cmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dir_bit(dir_bit),
    .cmp_out(cmp_out), .cmp_oe(cmp_oe), .match_pulse(match_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; dir_bit = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 cmp", v, 0);
    rd(2'd2, v); chk("R1 count", v, 0);
    chk("R1 cmp_out", cmp_out, 0);
    chk("R1 pulse", match_pulse, 0);
  endtask

  task automatic t_regs();
    int v;
    do_reset();
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 bit7", v, 8'h7F);
    wr(2'd0, 8'h55); rd(2'd0, v); chk("R2 ctrl", v, 8'h55);
    wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 cmp", v, 8'hA5);
  endtask

  task automatic t_stop();
    int v; int p = 0;
    do_reset();
    wr(2'd0, 8'h01); step(5);
    wr(2'd0, 8'h00);
    rd(2'd2, v); chk("R3 count at stop", v, 6);
    for (int i = 0; i < 20; i++) begin @(negedge clk); p += match_pulse; end
    rd(2'd2, v); chk("R3 frozen", v, 6);
    chk("R3 no pulse", p, 0);
  endtask

  task automatic t_div1_wrap();
    int v;
    do_reset();
    wr(2'd0, 8'h01);
    step(10);  rd(2'd2, v); chk("R4 count10", v, 10);
    step(245); rd(2'd2, v); chk("R4 count255", v, 255);
    step(1);   rd(2'd2, v); chk("R4 wrap", v, 0);
  endtask

  task automatic t_divs();
    int v;
    for (int c = 2; c < 8; c++) begin
      int dv;
      dv = (c == 2) ? 8 : (c == 3) ? 32 : (c == 4) ? 64 :
           (c == 5) ? 128 : (c == 6) ? 256 : 1024;
      do_reset();
      wr(2'd0, 8'(c));
      step(dv - 1); rd(2'd2, v); chk($sformatf("R5 div%0d before", dv), v, 0);
      step(1);      rd(2'd2, v); chk($sformatf("R5 div%0d first", dv), v, 1);
      step(dv);     rd(2'd2, v); chk($sformatf("R5 div%0d second", dv), v, 2);
    end
  endtask

  task automatic t_restart_div1();
    int v;
    do_reset();
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h09);
    step(4); rd(2'd2, v); chk("R6 C-1", v, 4);
    step(1); rd(2'd2, v); chk("R6 C", v, 5);
    step(1); rd(2'd2, v); chk("R6 zero", v, 0);
    chk("R8 pulse with zero", match_pulse, 1);
    step(1); rd(2'd2, v); chk("R6 one", v, 1);
    chk("R8 pulse gone", match_pulse, 0);
  endtask

  task automatic t_restart_div8();
    int v;
    do_reset();
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h0A);
    step(16); rd(2'd2, v); chk("R7 C", v, 2);
    step(1);  rd(2'd2, v); chk("R7 zero first", v, 0);
    chk("R7 pulse", match_pulse, 1);
    step(6);  rd(2'd2, v); chk("R7 zero last", v, 0);
    step(1);  rd(2'd2, v); chk("R7 one", v, 1);
  endtask

  task automatic t_flag_once();
    int v; int p = 0;
    do_reset();
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h02);
    step(16);
    for (int i = 0; i < 8; i++) begin
      p += match_pulse;
      if (i == 1) chk("R8 pulse slot", match_pulse, 1);
      @(negedge clk);
    end
    chk("R8 single pulse", p, 1);
    rd(2'd2, v); chk("R8 no restart", v, 3);
  endtask

  task automatic t_actions();
    int p = 0;
    do_reset();
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h19);
    step(3); chk("R9 toggle before", cmp_out, 0);
    step(1); chk("R9 toggle high", cmp_out, 1);
    step(4); chk("R9 toggle low", cmp_out, 0);
    do_reset();
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h39);
    step(4); chk("R9 set", cmp_out, 1);
    wr(2'd0, 8'h09);
    for (int i = 0; i < 12; i++) begin @(negedge clk); p += match_pulse; end
    chk("R9 off keeps line", cmp_out, 1);
    chk("R9 off still matches", int'(p > 0), 1);
    wr(2'd0, 8'h29);
    step(8); chk("R9 clear", cmp_out, 0);
  endtask

  task automatic t_oe();
    do_reset();
    wr(2'd0, 8'h10);
    dir_bit = 1'b1; #1; chk("R10 on", cmp_oe, 1);
    dir_bit = 1'b0; #1; chk("R10 dir off", cmp_oe, 0);
    @(negedge clk);
    wr(2'd0, 8'h00);
    dir_bit = 1'b1; #1; chk("R10 action off", cmp_oe, 0);
    @(negedge clk);
  endtask

  task automatic t_cmp_update();
    int p = 0;
    do_reset();
    wr(2'd1, 8'd200);
    wr(2'd0, 8'h01);
    step(10);
    wr(2'd1, 8'd20);
    for (int n = 11; n < 21; n++) begin p += match_pulse; @(negedge clk); end
    chk("R11 no early pulse", p, 0);
    chk("R11 new compare", match_pulse, 1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_stop();
    t_div1_wrap();
    t_divs();
    t_restart_div1();
    t_restart_div8();
    t_flag_once();
    t_actions();
    t_oe();
    t_cmp_update();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule